// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits beside a CPU bus and decides how many extra cycles each memory access has to wait. The top byte of the access address selects a region. The cost of the access depends on that region, on the access width (16 or 32 bit) and on whether the access is sequential. Three external ROM windows and a backup-SRAM window take their timings from a 16-bit wait-control register. Every other region in the lower sixteen has a fixed cost. Regions 16 and above cost nothing.

A requester presents an address, a width flag and a sequential flag together with `req_valid`. When `ready` is high the block accepts the request and then holds `ready` low for exactly the computed number of cycles. The region of the most recent accepted request becomes the active region. The 16- and 32-bit non-sequential costs of that region are exported continuously as prefetch costs, and they follow register writes on the next cycle.

The control is a two-state machine. ST_READY means the bus is free and `ready` is high. ST_STALL means a wait is being counted down. The transitions are: *grant* (ST_READY to ST_STALL, on a request whose cost is not zero); *pass* (ST_READY to ST_READY, when there is no request or the request costs zero); *countdown* (ST_STALL to ST_STALL while more than one wait cycle is left); *release* (ST_STALL to ST_READY on the last wait cycle).

Top module: `bus_wait_gen`

## Requirements
- R1: The region index is `req_addr[31:24]`. Any region index of 16 or more costs 0 cycles for all four access kinds, and so does the prefetch cost of such a region.
- R2: After reset the control register reads 0. With that value the 16-bit non-sequential waits are 2 for region 2, 4 for regions 8 to 14 and 0 for every other region. The 16-bit sequential waits are 2 for region 2, then 2, 2, 4, 4, 8, 8 for regions 8 to 13, 4 for region 14 and 0 elsewhere.
- R3: For regions 0 to 15, a 32-bit non-sequential access costs (16-bit non-sequential + 16-bit sequential + 1) and a 32-bit sequential access costs (2 × 16-bit sequential + 1).
- R4: The 2-bit first-access codes 0, 1, 2 and 3 give 4, 3, 2 and 8 cycles. The field at bits [3:2] sets regions 8 and 9. The field at bits [6:5] sets regions 10 and 11. The field at bits [9:8] sets regions 12 and 13. The field at bits [1:0] sets both 16-bit costs (sequential and non-sequential) of region 14.
- R5: Bits 4, 7 and 10 set the 16-bit sequential waits of windows 0, 1 and 2 (regions 8/9, 10/11 and 12/13). A value of 0 gives 2, 4 or 8 cycles respectively, and a value of 1 gives 1 cycle.
- R6: After an accepted request of cost N, `ready` is low for exactly N cycles. If N is 0, `ready` stays high. A `req_valid` pulse while `ready` is low is ignored: it neither lengthens the wait nor changes the active region.
- R7: `pf_cost16` and `pf_cost32` equal the 16- and 32-bit non-sequential costs of the active region. The active region is 0 after reset and is set by each accepted request. The cycle after a register write, both values reflect the new register contents.
- R8: A register write stores `cfg_wdata & 16'h47FF`, so unused bits read back as 0. Bit 14 drives `pf_en` and has no effect on any wait count.
- R9: The length of a wait is fixed when the request is accepted. A register write during ST_STALL does not change the wait in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-control register |
| cfg_wdata | input | 16 | Write data for the wait-control register |
| cfg_rdata | output | 16 | Current contents of the wait-control register |
| pf_en | output | 1 | Prefetch-enable flag (register bit 14) |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_seq | input | 1 | 1 = sequential access |
| ready | output | 1 | High when the bus is free; low while waiting |
| pf_cost16 | output | 5 | 16-bit non-sequential cost of the active region |
| pf_cost32 | output | 5 | 32-bit non-sequential cost of the active region |

## Verification
The bench sweeps 32 register settings. In each setting the three windows and the SRAM field carry different codes. Each setting is checked across regions 0 to 17, 0x80 and 0xFF and across all four access kinds. The bench measures the length of every stall and compares it with an arithmetic model, so a swapped code table or a window wired to the wrong field produces wrong stall lengths in only some regions.

The bench also targets these cases, each with the failure it would expose:
- Zero-cost regions: a design that stalls one cycle too many or too few on them shows up here.
- Region 15 and regions above 15 for 32-bit accesses: the first must cost 1 and the others 0, so a design that confuses the two fails.
- Bit 14 and unused bits: a design that lets either of them leak into a cost fails.
- A register write in the middle of a stall: a design that recomputes the wait in progress fails.
- A request pulse while stalled: a design that accepts it, or moves the active region to it, fails.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned REGION_W = 8;
    localparam int unsigned CFG_W    = 16;
    localparam int unsigned WAIT_W   = 5;

    // number of region indices that carry a nonzero table entry
    localparam int unsigned TBL_REGIONS = 16;
    // ROM windows controlled by the register
    localparam int unsigned NUM_WIN     = 3;
    // register fields: SRAM code at 0, window w code at 2+3w, seq bit at 4+3w
    localparam int unsigned SRAM_LSB    = 0;
    localparam int unsigned WIN_STRIDE  = 3;
    localparam int unsigned WIN_LSB0    = 2;
    localparam int unsigned WIN_SEQ0    = 4;
    localparam int unsigned PF_BIT      = 14;
    localparam int unsigned USED_LOW    = WIN_SEQ0 + WIN_STRIDE * (NUM_WIN - 1) + 1;
    localparam logic [CFG_W-1:0] CFG_MASK =
        CFG_W'((1 << USED_LOW) - 1) | CFG_W'(1 << PF_BIT);

    // fixed region numbers
    localparam int unsigned RGN_SLOW_RAM = 2;
    localparam int unsigned RGN_WIN_BASE = 8;
    localparam int unsigned RGN_SRAM     = 14;
    localparam int unsigned SLOW_RAM_WS  = 2;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_STALL = 1'b1
    } bwg_state_e;

    // shared first-access code map: 0->4, 1->3, 2->2, 3->8
    function automatic logic [WAIT_W-1:0] first_wait(input logic [1:0] code);
        logic [WAIT_W-1:0] w;
        case (code)
            2'd0:    w = WAIT_W'(4);
            2'd1:    w = WAIT_W'(3);
            2'd2:    w = WAIT_W'(2);
            default: w = WAIT_W'(8);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
    import bwg_pkg::*;
#(
    parameter int unsigned W = CFG_W,
    parameter logic [W-1:0] MASK = CFG_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & MASK;
        end
    end

endmodule

// File: rtl/bwg_cost_lut.sv
module bwg_cost_lut
    import bwg_pkg::*;
#(
    parameter int unsigned RW = REGION_W,
    parameter int unsigned WW = WAIT_W,
    parameter int unsigned CW = CFG_W
) (
    input  logic [CW-1:0] cfg,
    input  logic [RW-1:0] region,
    output logic [WW-1:0] n16,
    output logic [WW-1:0] s16,
    output logic [WW-1:0] n32,
    output logic [WW-1:0] s32
);

    localparam int unsigned IDX_W = $clog2(TBL_REGIONS);

    logic [WW-1:0] win_first [NUM_WIN];
    logic [WW-1:0] win_seq   [NUM_WIN];
    logic [WW-1:0] sram_ws;
    logic          in_tbl;
    logic [IDX_W-1:0] idx;

    // per-window decode of the register fields
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int unsigned CODE_LSB = WIN_LSB0 + WIN_STRIDE * w;
        localparam int unsigned SEQ_BIT  = WIN_SEQ0 + WIN_STRIDE * w;
        assign win_first[w] = WW'(first_wait(cfg[CODE_LSB +: 2]));
        assign win_seq[w]   = cfg[SEQ_BIT] ? WW'(1) : (WW'(2) << w);
    end

    assign sram_ws = WW'(first_wait(cfg[SRAM_LSB +: 2]));
    assign in_tbl  = (region < RW'(TBL_REGIONS));
    assign idx     = region[IDX_W-1:0];

    always_comb begin
        n16 = '0;
        s16 = '0;
        if (in_tbl) begin
            case (idx)
                IDX_W'(RGN_SLOW_RAM): begin
                    n16 = WW'(SLOW_RAM_WS);
                    s16 = WW'(SLOW_RAM_WS);
                end
                IDX_W'(RGN_WIN_BASE), IDX_W'(RGN_WIN_BASE + 1): begin
                    n16 = win_first[0];
                    s16 = win_seq[0];
                end
                IDX_W'(RGN_WIN_BASE + 2), IDX_W'(RGN_WIN_BASE + 3): begin
                    n16 = win_first[1];
                    s16 = win_seq[1];
                end
                IDX_W'(RGN_WIN_BASE + 4), IDX_W'(RGN_WIN_BASE + 5): begin
                    n16 = win_first[2];
                    s16 = win_seq[2];
                end
                IDX_W'(RGN_SRAM): begin
                    n16 = sram_ws;
                    s16 = sram_ws;
                end
                default: begin
                    n16 = '0;
                    s16 = '0;
                end
            endcase
        end
    end

    assign n32 = in_tbl ? (n16 + s16 + WW'(1)) : '0;
    assign s32 = in_tbl ? ((s16 << 1) + WW'(1)) : '0;

endmodule

// File: rtl/bwg_wait_fsm.sv
module bwg_wait_fsm
    import bwg_pkg::*;
#(
    parameter int unsigned WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [WW-1:0] req_cost,
    output logic          ready,
    output logic          accept
);

    bwg_state_e    state, state_nx;
    logic [WW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_READY: begin
                if (req_valid && (req_cost != '0)) begin
                    state_nx = ST_STALL;      // grant
                    cnt_nx   = req_cost;
                end
            end
            ST_STALL: begin
                cnt_nx = cnt - WW'(1);        // countdown
                if (cnt == WW'(1)) begin
                    state_nx = ST_READY;      // release
                end
            end
            default: begin
                state_nx = ST_READY;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready  = (state == ST_READY);
        accept = (state == ST_READY) && req_valid;
    end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwg_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned RW = REGION_W,
    parameter int unsigned CW = CFG_W,
    parameter int unsigned WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_rdata,
    output logic          pf_en,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wide,
    input  logic          req_seq,
    output logic          ready,
    output logic [WW-1:0] pf_cost16,
    output logic [WW-1:0] pf_cost32
);

    logic [CW-1:0] cfg_q;
    logic [RW-1:0] req_region;
    logic [RW-1:0] act_region;
    logic [WW-1:0] rq_n16, rq_s16, rq_n32, rq_s32;
    logic [WW-1:0] ac_n16, ac_s16, ac_n32, ac_s32;
    logic [WW-1:0] req_cost;
    logic          accept;

    assign req_region = req_addr[AW-1 -: RW];

    bwg_cfg_reg #(.W(CW), .MASK(CFG_MASK)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    bwg_cost_lut #(.RW(RW), .WW(WW), .CW(CW)) u_req_lut (
        .cfg    (cfg_q),
        .region (req_region),
        .n16    (rq_n16),
        .s16    (rq_s16),
        .n32    (rq_n32),
        .s32    (rq_s32)
    );

    bwg_cost_lut #(.RW(RW), .WW(WW), .CW(CW)) u_act_lut (
        .cfg    (cfg_q),
        .region (act_region),
        .n16    (ac_n16),
        .s16    (ac_s16),
        .n32    (ac_n32),
        .s32    (ac_s32)
    );

    always_comb begin
        unique case ({req_wide, req_seq})
            2'b00:   req_cost = rq_n16;
            2'b01:   req_cost = rq_s16;
            2'b10:   req_cost = rq_n32;
            default: req_cost = rq_s32;
        endcase
    end

    bwg_wait_fsm #(.WW(WW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cost  (req_cost),
        .ready     (ready),
        .accept    (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_region <= '0;
        end else if (accept) begin
            act_region <= req_region;
        end
    end

    assign cfg_rdata = cfg_q;
    assign pf_en     = cfg_q[PF_BIT];
    assign pf_cost16 = ac_n16;
    assign pf_cost32 = ac_n32;

endmodule

// File: rtl/bwg_checker.sv
module bwg_checker
    import bwg_pkg::*;
#(
    parameter int unsigned CW = CFG_W,
    parameter int unsigned WW = WAIT_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [CW-1:0] cfg_wdata,
    input logic [CW-1:0] cfg_rdata,
    input logic          pf_en,
    input logic          req_valid,
    input logic [WW-1:0] req_cost,
    input logic          ready,
    input logic [WW-1:0] pf_cost16,
    input logic [WW-1:0] pf_cost32
);

    // independent countdown of remaining stall cycles
    logic [WW-1:0] left;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (ready && req_valid) begin
            left <= req_cost;
        end else if (!ready && left != '0) begin
            left <= left - WW'(1);
        end
    end

    p_zero_cost_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_cost == '0) |=> ready);

    p_grant_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_cost != '0) |=> !ready);

    p_stall_not_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (left != '0));

    p_stall_not_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (left == '0));

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CFG_MASK) == '0);

    p_pf_en_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_en == cfg_rdata[PF_BIT]);

    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_MASK)));

    p_wide_costlier_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_cost32 > pf_cost16) || (pf_cost32 == '0 && pf_cost16 == '0));

endmodule

bind bus_wait_gen bwg_checker #(.CW(CW), .WW(WW)) u_bwg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pf_en     (pf_en),
    .req_valid (req_valid),
    .req_cost  (req_cost),
    .ready     (ready),
    .pf_cost16 (pf_cost16),
    .pf_cost32 (pf_cost32)
);

// File: tb/tb_bus_wait_gen.sv
module tb_bus_wait_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        pf_en;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_wide = 1'b0;
    logic        req_seq = 1'b0;
    logic        ready;
    logic [4:0]  pf_cost16;
    logic [4:0]  pf_cost32;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    bus_wait_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pf_en(pf_en), .req_valid(req_valid),
        .req_addr(req_addr), .req_wide(req_wide), .req_seq(req_seq),
        .ready(ready), .pf_cost16(pf_cost16), .pf_cost32(pf_cost32)
    );

    // ---------------- reference model (from the requirements) -------------
    function automatic int fw(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 3 : (c == 2'd2) ? 2 : 8;
    endfunction

    function automatic int m_n16(input logic [15:0] c, input int r);
        if (r >= 16) return 0;
        case (r)
            2:       return 2;
            8, 9:    return fw(c[3:2]);
            10, 11:  return fw(c[6:5]);
            12, 13:  return fw(c[9:8]);
            14:      return fw(c[1:0]);
            default: return 0;
        endcase
    endfunction

    function automatic int m_s16(input logic [15:0] c, input int r);
        if (r >= 16) return 0;
        case (r)
            2:       return 2;
            8, 9:    return c[4]  ? 1 : 2;
            10, 11:  return c[7]  ? 1 : 4;
            12, 13:  return c[10] ? 1 : 8;
            14:      return fw(c[1:0]);
            default: return 0;
        endcase
    endfunction

    function automatic int m_cost(input logic [15:0] c, input int r,
                                  input bit wide, input bit seq);
        if (r >= 16) return 0;
        if (!wide) return seq ? m_s16(c, r) : m_n16(c, r);
        return seq ? 2 * m_s16(c, r) + 1 : m_n16(c, r) + m_s16(c, r) + 1;
    endfunction

    // ---------------- helpers ----------------------------------------------
    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issues one request and returns the number of cycles ready was low
    task automatic do_req(input int r, input bit wide, input bit seq,
                          output int low);
        @(negedge clk);
        req_addr  = {r[7:0], 24'h5a3c10};
        req_wide  = wide;
        req_seq   = seq;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        low = 0;
        while (!ready && low < 64) begin
            low++;
            @(negedge clk);
        end
    endtask

    function automatic int reg_of(input int i);
        return (i < 18) ? i : (i == 18) ? 8'h80 : 8'hFF;
    endfunction

    // ---------------- watchdog ---------------------------------------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ---------------------------------------------
    initial begin
        int low;
        logic [15:0] cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2", "cfg_rdata", cfg_rdata, 0);
        check("R6", "ready after reset", ready, 1);
        check("R8", "pf_en after reset", pf_en, 0);
        check("R7", "pf_cost16 after reset", pf_cost16, 0);
        check("R7", "pf_cost32 after reset", pf_cost32, 1);

        // R2 reset table, literal spot values plus full sweep
        do_req(12, 1'b0, 1'b1, low);
        check("R2", "region 12 seq16", low, 8);
        do_req(14, 1'b0, 1'b0, low);
        check("R2", "region 14 nseq16", low, 4);
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < 4; k++) begin
                do_req(reg_of(i), k[1], k[0], low);
                check("R2", $sformatf("reset cost region %0d kind %0d", reg_of(i), k),
                      low, m_cost(16'h0000, reg_of(i), k[1], k[0]));
            end
        end

        // R1 R3 R4 R5 R7 R8: sweep of register settings
        for (int s = 0; s < 32; s++) begin
            logic [1:0] c0, c1, c2, cs;
            c0 = s[1:0];
            c1 = 2'(s[1:0] + 2);
            c2 = 2'(s[1:0] + 3);
            cs = 2'(s[1:0] + 1);
            cfg = {1'b0, s[2], 3'b000, s[4], c2, s[3], c1, s[2], c0, cs};
            // odd settings also set unused bits, which must be dropped (R8)
            write_cfg(s[0] ? (cfg | 16'hB800) : cfg);
            @(negedge clk);
            check("R8", "readback", cfg_rdata, cfg);
            check("R8", "pf_en", pf_en, cfg[14]);
            for (int i = 0; i < 20; i++) begin
                for (int k = 0; k < 4; k++) begin
                    int r;
                    r = reg_of(i);
                    do_req(r, k[1], k[0], low);
                    check((r >= 16) ? "R1" : (k[1] ? "R3" : "R4/R5"),
                          $sformatf("cfg %h region %0d kind %0d", cfg, r, k),
                          low, m_cost(cfg, r, k[1], k[0]));
                    check("R7", "pf_cost16", pf_cost16, m_n16(cfg, r));
                    check("R7", "pf_cost32", pf_cost32,
                          (r >= 16) ? 0 : m_n16(cfg, r) + m_s16(cfg, r) + 1);
                end
            end
        end

        // R7 refresh after write, active region 12
        write_cfg(16'h0000);
        do_req(12, 1'b0, 1'b0, low);
        write_cfg(16'h0100);               // window 2 code 1 -> 3
        check("R7", "refresh pf_cost16", pf_cost16, 3);
        check("R7", "refresh pf_cost32", pf_cost32, 3 + 8 + 1);

        // R9 write in the middle of a stall
        write_cfg(16'h0300);               // window 2 code 3 -> 8
        @(negedge clk);
        req_addr = 32'h0C00_0000; req_wide = 1'b0; req_seq = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        low = 0;
        while (!ready && low < 64) begin
            low++;
            if (low == 1) begin cfg_we = 1'b1; cfg_wdata = 16'h0200; end
            if (low == 2) cfg_we = 1'b0;
            @(negedge clk);
        end
        check("R9", "stall length with mid-wait write", low, 8);
        check("R9", "new setting visible", pf_cost16, 2);

        // R6 request pulse during a stall is ignored
        write_cfg(16'h0300);
        @(negedge clk);
        req_addr = 32'h0C00_0000; req_wide = 1'b0; req_seq = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        low = 0;
        while (!ready && low < 64) begin
            low++;
            if (low == 2) begin req_addr = 32'h3000_0000; req_valid = 1'b1; end
            if (low == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        check("R6", "stall length with ignored pulse", low, 8);
        check("R6", "active region kept", pf_cost16, 8);
        @(negedge clk);
        check("R6", "ready stays high afterwards", ready, 1);

        // R8 all-ones write and bit 14 has no effect on waits
        write_cfg(16'hFFFF);
        check("R8", "all-ones readback", cfg_rdata, 16'h47FF);
        check("R8", "pf_en set", pf_en, 1);
        do_req(10, 1'b1, 1'b1, low);
        check("R8", "cost with bit 14 set", low, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule